// File: doc/BRIEF.md
# Zero-Page and Stack-Page Relocation Unit

This unit sits on the address path between an 8-bit CPU with a 16-bit address bus and its memory. When the CPU addresses logical page zero (high address byte 0x00), the unit swaps in a high byte held in a register that software can write. When the CPU addresses the stack page (high byte 0x01), it can do the same with a second register. The low address byte always passes through untouched, so a relocated page is still exactly 256 bytes. Any other page goes through unchanged.

Page-zero reads and page-zero writes can be steered to different physical pages. When the dual-page mode bit is set, the CPU read/write line picks between a read page register and a write page register. When the bit is clear, both directions use the read page register. Software reaches the registers through a window of four consecutive addresses on the CPU's own bus. A register write takes effect on the clock edge that ends the CPU write cycle. The translated address is a purely combinational function of the CPU address, the read/write line and the registers.

Top module: `pgremap_top`

## Requirements
- R1: After reset the page-zero read register and the page-zero write register hold 0x00, the stack register holds 0x01 and dual-page mode is off, so `physAddr` equals `cpuAddr` for every address.
- R2: For a read whose high byte is 0x00, `physAddr[15:8]` is the page-zero read register and `physAddr[7:0]` equals `cpuAddr[7:0]`.
- R3: For any high byte other than 0x00 or 0x01, `physAddr` equals `cpuAddr`. This includes cycles that address the register window.
- R4: A valid write cycle (`cpuValid`=1, `cpuRnw`=0) to window offset 0 (`IO_BASE`+0) loads `cpuWdata` into the page-zero read register. The new value is visible from the next cycle.
- R5: While dual-page mode is off, page-zero writes are translated with the page-zero read register.
- R6: While dual-page mode is on, page-zero writes use the page-zero write register, which is loaded through offset 1, and page-zero reads still use the read register.
- R7: Accesses whose high byte is 0x01 use the stack register, loaded through offset 2, for both reads and writes, whatever the mode.
- R8: Read cycles to the window, and cycles with `cpuValid`=0, leave all registers unchanged.
- R9: `physAddr` follows `cpuAddr` and `cpuRnw` in the same cycle, with no register stage.
- R10: A write to offset 3 sets dual-page mode from `cpuWdata` bit 0. The other data bits have no effect. At most one register is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cpuAddr | input | 16 | Logical CPU address |
| cpuRnw | input | 1 | 1 = read cycle, 0 = write cycle |
| cpuValid | input | 1 | Current bus cycle is a real access |
| cpuWdata | input | 8 | CPU write data |
| physAddr | output | 16 | Translated physical address |

## Verification
The translated address is due in the same cycle as the address that produces it, so the monitor compares it one nanosecond after the falling edge on which the driver applied the inputs, with no pipeline offset. A register write changes translation only from the cycle after the rising edge that closes the write. The bench model therefore computes the expected value for the write cycle from the old register values and updates its own copy afterwards. The tests that check ignored stimulus (read cycles and invalid cycles aimed at the window) confirm at the ports, through a later translated address, that the targeted register kept its value.

// File: rtl/pgremap_pkg.sv
package pgremap_pkg;
  localparam int PAGE_W = 8;

  typedef struct packed {
    logic              wrZpRd;
    logic              wrZpWr;
    logic              wrStack;
    logic              wrCtrl;
    logic [PAGE_W-1:0] data;
  } regStrobe_t;
endpackage

// File: rtl/pgremap_ctrl.sv
module pgremap_ctrl
  import pgremap_pkg::*;
#(
  parameter int          ADDR_W  = 16,
  parameter logic [15:0] IO_BASE = 16'hFE00
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRnw,
  input  logic              cpuValid,
  input  logic [PAGE_W-1:0] cpuWdata,
  output regStrobe_t        strb
);
  localparam logic [ADDR_W-3:0] WIN_TAG = IO_BASE[ADDR_W-1:2];

  logic inWindow;
  logic wrCycle;

  always_comb begin
    inWindow = (cpuAddr[ADDR_W-1:2] == WIN_TAG);
    wrCycle  = cpuValid && !cpuRnw && inWindow;
    strb.wrZpRd  = wrCycle && (cpuAddr[1:0] == 2'd0);
    strb.wrZpWr  = wrCycle && (cpuAddr[1:0] == 2'd1);
    strb.wrStack = wrCycle && (cpuAddr[1:0] == 2'd2);
    strb.wrCtrl  = wrCycle && (cpuAddr[1:0] == 2'd3);
    strb.data    = cpuWdata;
  end

  // R10: at most one register is targeted per cycle
  p_one_strobe_r10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.wrZpRd, strb.wrZpWr, strb.wrStack, strb.wrCtrl}));

  // R8: read or idle cycles never produce a write strobe
  p_no_wr_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuRnw || !cpuValid) |->
      ({strb.wrZpRd, strb.wrZpWr, strb.wrStack, strb.wrCtrl} == 4'b0000));
endmodule

// File: rtl/pgremap_dpath.sv
module pgremap_dpath
  import pgremap_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter bit STACK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  regStrobe_t        strb,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRnw,
  output logic [ADDR_W-1:0] physAddr
);
  localparam int          LOW_W      = ADDR_W - PAGE_W;
  localparam logic [PAGE_W-1:0] ZP_PAGE    = '0;
  localparam logic [PAGE_W-1:0] STACK_PAGE = PAGE_W'(1);

  logic [PAGE_W-1:0] zpRdPage;
  logic [PAGE_W-1:0] zpWrPage;
  logic [PAGE_W-1:0] stackPage;
  logic              dualMode;
  logic [PAGE_W-1:0] cpuPage;
  logic [PAGE_W-1:0] outPage;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zpRdPage <= ZP_PAGE;
      zpWrPage <= ZP_PAGE;
      dualMode <= 1'b0;
    end else begin
      if (strb.wrZpRd) zpRdPage <= strb.data;
      if (strb.wrZpWr) zpWrPage <= strb.data;
      if (strb.wrCtrl) dualMode <= strb.data[0];
    end
  end

  generate
    if (STACK_EN) begin : g_stack
      logic [PAGE_W-1:0] stackReg;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)             stackReg <= STACK_PAGE;
        else if (strb.wrStack) stackReg <= strb.data;
      end
      assign stackPage = stackReg;

      // R7: stack register loads the written byte
      p_stack_upd_r7: assert property (@(posedge clk) disable iff (!rstN)
        strb.wrStack |=> (stackPage == $past(strb.data)));
    end else begin : g_nostack
      assign stackPage = STACK_PAGE;
    end
  endgenerate

  always_comb begin
    cpuPage = cpuAddr[ADDR_W-1:LOW_W];
    if (cpuPage == ZP_PAGE)
      outPage = (dualMode && !cpuRnw) ? zpWrPage : zpRdPage;
    else if (cpuPage == STACK_PAGE)
      outPage = stackPage;
    else
      outPage = cpuPage;
    physAddr = {outPage, cpuAddr[LOW_W-1:0]};
  end

  // R4: read page register takes the written byte on the closing edge
  p_zprd_upd_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrZpRd |=> (zpRdPage == $past(strb.data)));

  // R8: without a strobe, the page registers and mode keep their values
  p_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.wrZpRd || strb.wrZpWr || strb.wrCtrl) |=>
      ($stable(zpRdPage) && $stable(zpWrPage) && $stable(dualMode)));
endmodule

// File: rtl/pgremap_top.sv
module pgremap_top
  import pgremap_pkg::*;
#(
  parameter int          ADDR_W   = 16,
  parameter logic [15:0] IO_BASE  = 16'hFE00,
  parameter bit          STACK_EN = 1'b1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] cpuAddr,
  input  logic              cpuRnw,
  input  logic              cpuValid,
  input  logic [7:0]        cpuWdata,
  output logic [ADDR_W-1:0] physAddr
);
  regStrobe_t strb;

  pgremap_ctrl #(.ADDR_W(ADDR_W), .IO_BASE(IO_BASE)) ctrl_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRnw(cpuRnw),
    .cpuValid(cpuValid), .cpuWdata(cpuWdata), .strb(strb)
  );

  pgremap_dpath #(.ADDR_W(ADDR_W), .STACK_EN(STACK_EN)) dpath_i (
    .clk(clk), .rstN(rstN), .strb(strb), .cpuAddr(cpuAddr),
    .cpuRnw(cpuRnw), .physAddr(physAddr)
  );

  // R3: pages other than zero and stack pass straight through
  p_pass_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cpuAddr[ADDR_W-1:ADDR_W-8] > 8'h01) |-> (physAddr == cpuAddr));

  // R2: the low byte is never altered
  p_low_byte_r2: assert property (@(posedge clk) disable iff (!rstN)
    physAddr[7:0] == cpuAddr[7:0]);
endmodule

// File: tb/pgremap_top_tb_top.sv
module pgremap_top_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] cpuAddr = 16'h0000;
  logic        cpuRnw = 1'b1;
  logic        cpuValid = 1'b0;
  logic [7:0]  cpuWdata = 8'h00;
  logic [15:0] physAddr;

  int nRun = 0;
  int nFail = 0;
  bit done = 1'b0;

  logic [15:0] expQ[$];
  string       tagQ[$];

  logic [7:0] mRd = 8'h00, mWr = 8'h00, mSt = 8'h01;
  logic       mDual = 1'b0;

  always #2 clk = ~clk;

  pgremap_top dut_i (
    .clk(clk), .rstN(rstN), .cpuAddr(cpuAddr), .cpuRnw(cpuRnw),
    .cpuValid(cpuValid), .cpuWdata(cpuWdata), .physAddr(physAddr)
  );

  function automatic logic [15:0] model(input logic [15:0] a, input logic rnw);
    logic [7:0] hi;
    hi = a[15:8];
    if (hi == 8'h00)      hi = (mDual && !rnw) ? mWr : mRd;
    else if (hi == 8'h01) hi = mSt;
    return {hi, a[7:0]};
  endfunction

  task automatic busCycle(input logic [15:0] a, input logic rnw, input logic vld,
                          input logic [7:0] d, input string tag);
    @(negedge clk);
    cpuAddr = a; cpuRnw = rnw; cpuValid = vld; cpuWdata = d;
    expQ.push_back(model(a, rnw));
    tagQ.push_back(tag);
    if (rstN && vld && !rnw && a[15:2] == 14'h3F80) begin
      case (a[1:0])
        2'd0: mRd = d;
        2'd1: mWr = d;
        2'd2: mSt = d;
        default: mDual = d[0];
      endcase
    end
  endtask

  // monitor: compare within the same cycle as the stimulus (R9)
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (expQ.size() > 0) begin
        logic [15:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        nRun++;
        if (physAddr !== e) begin
          nFail++;
          $display("FAIL %s: physAddr=%h expected=%h", t, physAddr, e);
        end
      end
    end
  end

  initial begin
    for (int i = 0; i < 20000; i++) @(posedge clk);
    if (!done) begin
      nFail++;
      $display("FAIL watchdog: run did not end, actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    busCycle(16'h0012, 1'b1, 1'b1, 8'h00, "R1 reset zp");
    busCycle(16'h01FF, 1'b0, 1'b1, 8'h00, "R1 reset stack");
    @(negedge clk); rstN = 1'b1;
    busCycle(16'h0080, 1'b1, 1'b1, 8'h00, "R1 identity read");
    busCycle(16'h0080, 1'b0, 1'b1, 8'h00, "R1 identity write");
    busCycle(16'hFE00, 1'b0, 1'b1, 8'h40, "R3 window passes, R4 load");
    busCycle(16'h0055, 1'b1, 1'b1, 8'h00, "R2 R4 R9 zp read");
    busCycle(16'h0055, 1'b0, 1'b1, 8'h00, "R5 zp write single mode");
    busCycle(16'hFE01, 1'b0, 1'b1, 8'h70, "R6 load write page");
    busCycle(16'h00AA, 1'b0, 1'b1, 8'h00, "R5 write page unused");
    busCycle(16'hFE01, 1'b1, 1'b1, 8'h99, "R8 read to window");
    busCycle(16'hFE03, 1'b0, 1'b1, 8'h01, "R10 dual on");
    busCycle(16'h0010, 1'b1, 1'b1, 8'h00, "R6 dual read");
    busCycle(16'h00FF, 1'b0, 1'b1, 8'h00, "R6 R8 dual write");
    busCycle(16'hFE00, 1'b0, 1'b0, 8'h22, "R8 invalid cycle");
    busCycle(16'h0001, 1'b1, 1'b1, 8'h00, "R8 read page kept");
    busCycle(16'hFE02, 1'b0, 1'b1, 8'h9A, "R7 load stack");
    busCycle(16'h01C3, 1'b1, 1'b1, 8'h00, "R7 stack read");
    busCycle(16'h01C3, 1'b0, 1'b1, 8'h00, "R7 stack write");
    busCycle(16'h0200, 1'b1, 1'b1, 8'h00, "R3 page 2");
    busCycle(16'hFFFF, 1'b0, 1'b1, 8'h00, "R3 top");
    busCycle(16'h1234, 1'b1, 1'b1, 8'h00, "R3 mid");
    busCycle(16'hFE05, 1'b0, 1'b1, 8'h55, "R3 outside window");
    busCycle(16'h0033, 1'b0, 1'b1, 8'h00, "R6 outside window no effect");
    busCycle(16'hFE03, 1'b0, 1'b1, 8'hFE, "R10 dual off upper bits");
    busCycle(16'h0005, 1'b0, 1'b1, 8'h00, "R10 R5 back to single");
    busCycle(16'hFE00, 1'b0, 1'b1, 8'h00, "R4 restore");
    busCycle(16'h0000, 1'b1, 1'b1, 8'h00, "R4 identity again");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end
endmodule